// File: doc/BRIEF.md
# Broadcast Group Address Filter

This receiver-side block examines a broadcast packet as it streams past, one byte per accepted beat, and decides whether the packet is addressed to this node. The leading bit of the packet (bit 7 of the first byte) selects one of two addressing forms. With the flag clear, the rest of the packet is a membership bitmap holding one bit per device. With the flag set, the packet names exactly one device by its 8-bit label. The node's own 8-bit identity is a static input. It is captured when the first byte of each packet is accepted.

The stream input has a valid/ready handshake. Ready is always high. The decision appears as a single-cycle pulse in the cycle after the byte marked last is accepted. Framing, integrity checks and acting on the command belong to other blocks.

The control is a four-state machine. HEAD waits for the first byte of a packet. MAP scans bitmap bytes. LABEL waits for the byte that completes the label. DRAIN discards any bytes that follow a complete label. The transitions are as follows:
- HEAD goes to MAP on a non-last byte with the flag 0, and to LABEL on a non-last byte with the flag 1.
- HEAD stays in HEAD on a one-byte packet.
- MAP returns to HEAD on the last byte.
- LABEL goes to HEAD on a last byte, or to DRAIN on a non-last byte.
- DRAIN returns to HEAD on the last byte.

Top module: `grp_addr_filter`

## Requirements
- R1: `in_ready` is 1 in every cycle.
- R2: When bit 7 of the first byte is 0 (bitmap form), device k owns global bit position k+1, with positions counted MSB-first across the packet. That position is byte (k+1)/8, bit 7-((k+1) mod 8), where bit 7 is the MSB. The packet matches when that bit is 1.
- R3: In bitmap form, bits belonging to other devices never produce a match, even when all of them are 1.
- R4: A bitmap packet that ends before the byte holding the node's bit gives no match. A packet that ends exactly on that byte is evaluated normally.
- R5: When bit 7 of the first byte is 1 (label form), the label is bits 6..0 of the first byte as its upper seven bits, followed by bit 7 of the second byte as its LSB. The packet matches only when the label equals the node ID.
- R6: A label-form packet only one byte long gives no match. Bytes after the second one in a label-form packet have no effect.
- R7: `hit_pulse` is high for exactly one cycle, in the cycle after a matching packet's last byte is accepted. It is low at all other times.
- R8: The node ID is sampled with the first byte of a packet. Changes to `node_id` later in the packet have no effect on that packet's decision.
- R9: During and directly after reset, `hit_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_ready | output | 1 | Always 1 |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Marks the final byte of a packet |
| node_id | input | 8 | This node's identity |
| hit_pulse | output | 1 | One-cycle match indication |

## Verification
In a one-byte packet, several things happen in the same cycle: the head decode (flag test and ID capture) and the end-of-packet decision. For devices 0 to 6 the bitmap bit under test also lies in that same head byte. The bench provokes this with minimal bitmap packets whose length ends exactly on the node's byte, and with one-byte label packets. It judges each against the arithmetic bit position and against the rule that a one-byte label never matches. It also changes `node_id` on the beat after the head in every packet, so a design that reads the live ID instead of the captured one miscompares.

// File: rtl/gaf_pkg.sv
package gaf_pkg;
    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,
        ST_MAP   = 2'd1,
        ST_LBL   = 2'd2,
        ST_DRAIN = 2'd3
    } gaf_state_e;
endpackage

// File: rtl/gaf_locator.sv
// Maps a device ID to the byte index and in-byte bit that carry its
// membership flag. The global position is ID+1, counted MSB-first.
module gaf_locator #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic [DATA_W-1:0]         id_i,
    output logic [IDX_W-1:0]          idx_o,
    output logic [$clog2(DATA_W)-1:0] bit_o
);
    localparam int BSH = $clog2(DATA_W);
    localparam logic [BSH-1:0] TOP_BIT = BSH'(DATA_W - 1);

    logic [DATA_W:0] pos;

    always_comb begin
        pos   = {1'b0, id_i} + (DATA_W+1)'(1);
        idx_o = IDX_W'(pos >> BSH);
        bit_o = TOP_BIT - pos[BSH-1:0];
    end
endmodule

// File: rtl/gaf_byte_counter.sv
// Index of the next byte within the packet. It saturates so that an
// overlong packet can never wrap back onto a target index.
module gaf_byte_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= W'(1);
        end else if (step_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + W'(1);
        end
    end
endmodule

// File: rtl/grp_addr_filter.sv
module grp_addr_filter
    import gaf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [DATA_W-1:0] node_id,
    output logic              hit_pulse
);
    localparam int BSH   = $clog2(DATA_W);
    localparam int IDX_W = DATA_W + 2 - BSH;

    gaf_state_e        state_q, state_d;
    logic [DATA_W-1:0] id_q;
    logic [DATA_W-2:0] lbl_q;
    logic              hit_q, hit_d;
    logic [IDX_W-1:0]  byte_cnt;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  tgt_idx;
    logic [BSH-1:0]    tgt_bit;
    logic [DATA_W-1:0] id_eff;
    logic [DATA_W-1:0] label_now;
    logic              accept, is_head, flag, bit_hit;

    assign in_ready  = 1'b1;
    assign accept    = in_valid;
    assign is_head   = (state_q == ST_HEAD);
    assign id_eff    = is_head ? node_id : id_q;
    assign cur_idx   = is_head ? '0 : byte_cnt;
    assign flag      = in_data[DATA_W-1];
    assign label_now = {lbl_q, in_data[DATA_W-1]};
    assign bit_hit   = (cur_idx == tgt_idx) && in_data[tgt_bit];

    gaf_locator #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_loc (
        .id_i  (id_eff),
        .idx_o (tgt_idx),
        .bit_o (tgt_bit)
    );

    gaf_byte_counter #(.W(IDX_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept && is_head),
        .step_i (accept && !is_head),
        .cnt_o  (byte_cnt)
    );

    // Next state and running decision
    always_comb begin
        state_d = state_q;
        hit_d   = hit_q;
        unique case (state_q)
            ST_HEAD: begin
                hit_d = !flag && bit_hit;
                if (accept && !in_last) state_d = flag ? ST_LBL : ST_MAP;
            end
            ST_MAP: begin
                hit_d = hit_q || bit_hit;
                if (accept && in_last) state_d = ST_HEAD;
            end
            ST_LBL: begin
                hit_d = (label_now == id_q);
                if (accept) state_d = in_last ? ST_HEAD : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (accept && in_last) state_d = ST_HEAD;
            end
            default: state_d = ST_HEAD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HEAD;
        else        state_q <= state_d;
    end

    // Outputs and captured packet fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_pulse <= 1'b0;
            hit_q     <= 1'b0;
            id_q      <= '0;
            lbl_q     <= '0;
        end else begin
            hit_pulse <= accept && in_last && hit_d;
            if (accept) hit_q <= hit_d;
            if (accept && is_head) begin
                id_q  <= node_id;
                lbl_q <= in_data[DATA_W-2:0];
            end
        end
    end
endmodule

// File: rtl/gaf_checker.sv
module gaf_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_last,
    input logic hit_pulse
);
    a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready);

    a_r7_pulse_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> $past(in_valid && in_last));

    a_r7_quiet_after_body: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_last) |=> !hit_pulse);

    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !hit_pulse);
endmodule

bind grp_addr_filter gaf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .hit_pulse (hit_pulse)
);

// File: tb/grp_addr_filter_tb.sv
module grp_addr_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       in_last;
    logic [7:0] node_id;
    logic       hit_pulse;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [7:0] pkt [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_addr_filter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .node_id   (node_id),
        .hit_pulse (hit_pulse)
    );

    task automatic chk(input logic act, input logic exp, input string req, input int id);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (id %0d): actual %0b expected %0b", req, id, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < NB; i++) pkt[i] = v;
    endtask

    task automatic put_bit(input int p, input logic v);
        pkt[p >> 3][7 - (p & 7)] = v;
    endtask

    // Streams pkt[0..len-1]; node_id is switched to alt after the head (R8)
    task automatic send(input int len, input logic exp, input logic [7:0] id,
                        input logic [7:0] alt, input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0) chk(hit_pulse, 1'b0, "R7 no pulse mid-packet", id);
            node_id  = (i == 0) ? id : alt;
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_last  = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(hit_pulse, exp, req, id);
        @(negedge clk);
        chk(hit_pulse, 1'b0, "R7 single-cycle pulse", id);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
        node_id  = '0;
        repeat (3) @(negedge clk);
        chk(hit_pulse, 1'b0, "R9 reset output", 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hit_pulse, 1'b0, "R9 after reset", 0);
        chk(in_ready, 1'b1, "R1 ready high", 0);

        for (int id = 0; id < 256; id++) begin
            logic [7:0] idb;
            logic [7:0] alt;
            int own_byte;
            idb      = 8'(id);
            alt      = idb ^ 8'h09;
            own_byte = (id + 1) >> 3;

            fill(8'h00); put_bit(id + 1, 1'b1);
            send(33, 1'b1, idb, alt, "R2 R8 own bit in full bitmap");

            fill(8'hFF); pkt[0] = 8'h7F; put_bit(id + 1, 1'b0);
            send(33, 1'b0, idb, alt, "R3 all other bits set");

            fill(8'h00); put_bit(id + 1, 1'b1);
            send(own_byte + 1, 1'b1, idb, alt, "R4 packet ends on own byte");

            if (own_byte > 0) begin
                fill(8'hFF); pkt[0] = 8'h7F;
                send(own_byte, 1'b0, idb, alt, "R4 packet too short");
            end

            fill(8'hFF);
            pkt[0] = {1'b1, idb[7:1]};
            pkt[1] = {idb[0], 7'h2A};
            send(4, 1'b1, idb, alt, "R5 R6 R8 label match, trailing bytes");

            pkt[1][7] = ~idb[0];
            send(2, 1'b0, idb, alt, "R5 label LSB differs");

            pkt[1][7] = idb[0];
            pkt[0][6] = ~idb[7];
            send(2, 1'b0, idb, alt, "R5 label MSB differs");

            fill(8'h00); pkt[0] = {1'b1, idb[7:1]};
            send(1, 1'b0, idb, alt, "R6 one-byte label");

            chk(in_ready, 1'b1, "R1 ready high", id);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule